// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block generates the system reset for a processor from two conditions: a supply-good flag from an external threshold comparator, and an active-low manual reset line. Both inputs are asynchronous, so each passes through a two-flop synchronizer first. Reset is driven on two complementary outputs, one active-low and one active-high. Reset is held for as long as the supply is low or the manual line is pulled low. Once both conditions clear, reset stays asserted for a fixed number of timebase ticks and then releases.

The pulse length is counted in ticks of a free-running timebase, not in clock cycles. With a 1 ms tick, a count of 200 gives a 200 ms stretch. Any fault seen during the stretch returns the sequencer to holding, and a full count starts again from the last release. This covers a brownout and every bounce edge of a mechanical pushbutton, so no separate debounce filter is needed.

The sequencer has three states:
- `ST_HOLD`: reset is held and the counter is kept loaded.
- `ST_STRETCH`: reset is held while the counter runs down on ticks.
- `ST_RUN`: reset is released.

The state changes are named as follows:
- `release` (`ST_HOLD` to `ST_STRETCH`) happens when both conditions are good.
- `fault` (`ST_STRETCH` or `ST_RUN` to `ST_HOLD`) happens on a low supply or a low manual line.
- `expire` (`ST_STRETCH` to `ST_RUN`) happens when the counter reaches zero.

Top module: `supv_reset_seq`

## Requirements
- R1: While the supply-good input is low, `sys_rst_n` is low. It goes low no later than 3 clock cycles after the input falls and stays low for as long as the input is low.
- R2: After the supply-good input returns high, `sys_rst_n` stays low until `PULSE_TICKS` ticks have been counted. It rises once the number of ticks seen since the input rose is PULSE_TICKS or PULSE_TICKS+1, because one tick can fall within the synchronizer latency.
- R3: A low level on `mreset_n_in` drives `sys_rst_n` low within 3 clock cycles.
- R4: After `mreset_n_in` rises, `sys_rst_n` stays low for a full pulse, counted under the same tick rule as R2.
- R5: `sys_rst` is at all times the exact complement of `sys_rst_n`.
- R6: A supply drop during a running pulse restarts it. After the final recovery, reset stays asserted for a full pulse.
- R7: Bounce on `mreset_n_in` has a specific effect on timing. Each low edge during the pulse reloads the count, and reset releases a full pulse after the last rising edge.
- R8: During asynchronous core reset `sys_rst_n` is low. After core reset is released with both inputs good, a full pulse elapses before release.
- R9: The pulse advances only on ticks. With no ticks, reset stays asserted indefinitely, and the full count remains once ticks resume.
- R10: With the supply good and the manual line high in `ST_RUN`, `sys_rst_n` stays high regardless of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| arst_n | input | 1 | Asynchronous core reset, active low |
| tick | input | 1 | One-cycle timebase tick |
| supply_ok_in | input | 1 | Asynchronous supply-good flag, high when the supply is above threshold |
| mreset_n_in | input | 1 | Asynchronous manual reset, active low |
| sys_rst_n | output | 1 | System reset, active low |
| sys_rst | output | 1 | System reset, active high |

## Verification
A sequencer stuck in the wrong state shows at the ports within three clock cycles of an input change. It appears either as reset failing to assert after a fault, or as reset releasing while a condition is still bad. A counter that loads the wrong value, misses a reload on a bounce, or counts clock cycles instead of ticks changes the number of ticks between the final release and the rising edge of `sys_rst_n`. The bench therefore measures that tick count for every episode. A broken complement output shows on the very next sample.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } supv_state_e;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int unsigned W       = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain[s] <= RST_VAL;
                    else         chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain[s] <= RST_VAL;
                    else         chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/supv_timer.sv
module supv_timer #(
    parameter int unsigned PULSE_TICKS = 200
) (
    input  logic clk,
    input  logic arst_n,
    input  logic load,
    input  logic run,
    input  logic tick,
    output logic expired
);
    import supv_pkg::*;

    localparam int unsigned CW = cnt_width(PULSE_TICKS);
    localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= LOAD_VAL;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R7
    reload_full_chk: assert property (@(posedge clk) disable iff (!arst_n)
        load |=> cnt_q == LOAD_VAL);

    // R9
    tick_only_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!load && !tick) |=> $stable(cnt_q));

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
        cnt_q <= LOAD_VAL);

endmodule

// File: rtl/supv_fsm.sv
module supv_fsm (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_ok,
    input  logic mreset_n,
    input  logic expired,
    output logic load,
    output logic run,
    output logic rst_n_q,
    output logic rst_q
);
    import supv_pkg::*;

    supv_state_e state_q, state_d;
    logic        fault;

    assign fault = !supply_ok || !mreset_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    if (!fault)      state_d = ST_STRETCH;
            ST_STRETCH: if (fault)       state_d = ST_HOLD;
                        else if (expired) state_d = ST_RUN;
            ST_RUN:     if (fault)       state_d = ST_HOLD;
            default:                     state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= ST_HOLD;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rst_n_q <= 1'b0;
            rst_q   <= 1'b1;
        end else begin
            rst_n_q <= (state_d == ST_RUN);
            rst_q   <= (state_d != ST_RUN);
        end
    end

    assign load = (state_q == ST_HOLD);
    assign run  = (state_q == ST_STRETCH);

    // R1
    supply_low_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !supply_ok |=> !rst_n_q);

    // R3
    manual_low_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !mreset_n |=> !rst_n_q);

    // R2
    release_after_count_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_n_q) |-> $past(expired));

    // R5
    complement_chk: assert property (@(posedge clk) disable iff (!arst_n)
        rst_q != rst_n_q);

    // R10
    run_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (rst_n_q && supply_ok && mreset_n) |=> rst_n_q);

endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq #(
    parameter int unsigned PULSE_TICKS = 200,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic tick,
    input  logic supply_ok_in,
    input  logic mreset_n_in,
    output logic sys_rst_n,
    output logic sys_rst
);

    logic [1:0] raw_in, synced;
    logic       load, run, expired;

    assign raw_in = {supply_ok_in, mreset_n_in};

    supv_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b00)
    ) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (raw_in),
        .q      (synced)
    );

    supv_fsm u_fsm (
        .clk       (clk),
        .arst_n    (arst_n),
        .supply_ok (synced[1]),
        .mreset_n  (synced[0]),
        .expired   (expired),
        .load      (load),
        .run       (run),
        .rst_n_q   (sys_rst_n),
        .rst_q     (sys_rst)
    );

    supv_timer #(
        .PULSE_TICKS (PULSE_TICKS)
    ) u_timer (
        .clk     (clk),
        .arst_n  (arst_n),
        .load    (load),
        .run     (run),
        .tick    (tick),
        .expired (expired)
    );

endmodule

// File: tb/sim_supv_reset_seq.sv
module sim_supv_reset_seq;

    localparam int P    = 8;
    localparam int TDIV = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic arst_n, tick, sup_in, mr_in, tick_en;
    logic rst_n_o, rst_o;
    int   cyc = 0;
    int   tcount = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    supv_reset_seq #(.PULSE_TICKS(P)) u0 (
        .clk          (clk),
        .arst_n       (arst_n),
        .tick         (tick),
        .supply_ok_in (sup_in),
        .mreset_n_in  (mr_in),
        .sys_rst_n    (rst_n_o),
        .sys_rst      (rst_o)
    );

    initial begin
        tick = 1'b0;
        tick_en = 1'b1;
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        tick = tick_en && (cyc % TDIV == 0);
    end

    always @(posedge clk) if (tick) tcount <= tcount + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // R5: complement checked on every sample outside core reset
    always @(negedge clk)
        if (arst_n === 1'b1 && !done)
            if (rst_o !== ~rst_n_o) chk(0, "R5", int'(rst_o), int'(~rst_n_o));

    function automatic bit rise_ok(input int d);
        return d >= P && d <= P + 1;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input string req);
        int t0 = tcount;
        int n  = 0;
        while (rst_n_o !== 1'b1 && n < (P + 3) * TDIV + 20) begin
            @(negedge clk);
            n++;
        end
        chk(rst_n_o === 1'b1 && rise_ok(tcount - t0), req, tcount - t0, P);
    endtask

    task automatic bounce_episode(input bit use_supply, input string req);
        int k = 1 + int'($urandom % 4);
        for (int b = 0; b < k; b++) begin
            if (use_supply) sup_in = 1'b0; else mr_in = 1'b0;
            cycles(3 + int'($urandom % 5));
            chk(rst_n_o === 1'b0, use_supply ? "R1" : "R3", int'(rst_n_o), 0);
            if (b < k - 1) begin
                if (use_supply) sup_in = 1'b1; else mr_in = 1'b1;
                cycles(1 + int'($urandom % (P * TDIV / 2)));
                chk(rst_n_o === 1'b0, req, int'(rst_n_o), 0);
            end
        end
        if (use_supply) sup_in = 1'b1; else mr_in = 1'b1;
        measure(req);
    endtask

    initial begin
        #5_000_000;
        chk(0, "watchdog", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        arst_n = 1'b0;
        sup_in = 1'b1;
        mr_in  = 1'b1;
        cycles(4);
        // R8: held during core reset
        chk(rst_n_o === 1'b0, "R8", int'(rst_n_o), 0);
        chk(rst_o === 1'b1, "R5", int'(rst_o), 1);
        arst_n = 1'b1;
        measure("R8");

        // R10: stays released while running with ticks present
        cycles(50);
        chk(rst_n_o === 1'b1, "R10", int'(rst_n_o), 1);

        // R1/R2: supply drop and recovery
        sup_in = 1'b0;
        cycles(3);
        chk(rst_n_o === 1'b0, "R1", int'(rst_n_o), 0);
        cycles(60);
        chk(rst_n_o === 1'b0, "R1", int'(rst_n_o), 0);
        sup_in = 1'b1;
        measure("R2");

        // R3/R4: manual reset press and release
        cycles(10);
        mr_in = 1'b0;
        cycles(3);
        chk(rst_n_o === 1'b0, "R3", int'(rst_n_o), 0);
        mr_in = 1'b1;
        measure("R4");

        // R6: brownout in the middle of a pulse
        cycles(10);
        sup_in = 1'b0;
        cycles(5);
        sup_in = 1'b1;
        cycles((P / 2) * TDIV);
        chk(rst_n_o === 1'b0, "R6", int'(rst_n_o), 0);
        sup_in = 1'b0;
        cycles(2);
        sup_in = 1'b1;
        measure("R6");

        // R9: no ticks, no release
        cycles(10);
        mr_in = 1'b0;
        cycles(5);
        tick_en = 1'b0;
        mr_in = 1'b1;
        cycles(200);
        chk(rst_n_o === 1'b0, "R9", int'(rst_n_o), 0);
        tick_en = 1'b1;
        measure("R9");

        // R7/R6: random bounce episodes
        for (int i = 0; i < 40; i++) begin
            bit sel = 1'($urandom % 2);
            cycles(5 + int'($urandom % 25));
            chk(rst_n_o === 1'b1, "R10", int'(rst_n_o), 1);
            bounce_episode(sel, sel ? "R6" : "R7");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule